// File: doc/BRIEF.md
# SPI DMA Transfer Sequencer

This block sits next to an SPI shift engine and moves 32-bit words between a simple request/acknowledge memory port and the engine's data registers. Software sets a start address, a byte count and a direction, then fires a one-shot start strobe. In the memory-to-SPI direction each word is fetched from memory and handed to the engine as a transmit word. In the SPI-to-memory direction the engine is given an all-zero transmit word, and the word it receives back is written to memory. Each word is one complete 32-bit exchange with the engine.

A one-shot stop strobe ends a run cleanly at the next word boundary and records an abort. A sticky status register, cleared by writing ones, holds a done event and an abort event. A mask register reduces the two events to a single interrupt line. While a run is in progress the sequencer owns the engine's data path. Processor writes to the transmit register and to the run configuration are dropped.

Top module: `spi_dma_seq`

## Requirements
- R1: The direction register (index 3, bit 0) selects the flow: 1 reads memory and feeds the engine, 0 writes each received engine word to memory (`mem_we` high on every request).
- R2: The byte-count register (index 2) is 24 bits wide and its two low bits are forced to zero on write. A run moves count/4 words, so the largest accepted count reads back as 0xFFFFFC.
- R3: The start-address register (index 1) has its two low bits forced to zero. The first memory request uses that address and each further word uses the previous address plus 4. The register itself keeps the programmed value.
- R4: The status register (index 4) sets bit 3 after the last word of a run completes and bit 4 when a run is aborted. No other status bits are ever set.
- R5: `irq` is high exactly when some status bit and the same bit of the mask register (index 5, bits 7:0) are both 1.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: Control register (index 0) writes carry a start strobe in bit 0 and a stop strobe in bit 1. A start while a run is active is ignored, and a stop while idle has no effect. A start with a count below 4 raises done at once with no memory access. Reading index 0 returns the busy flag in bit 0.
- R8: A stop during a run lets the current word finish, then ends the run early and sets abort (bit 4) rather than done.
- R9: Once raised, a memory request stays high with a stable address and direction until acknowledged. No request is raised while idle.
- R10: Every word is exactly one `eng_tx_load` pulse followed by one `eng_word_done`. In memory-to-SPI runs the loaded word is the fetched memory word. In SPI-to-memory runs the loaded word is zero and the stored word is the `eng_rx_data` of that exchange.
- R11: A write to the transmit register (index 6) while idle gives an `eng_tx_load` pulse with that data one cycle later. While a run is active such a write is ignored.
- R12: Writes to the address, count and direction registers while a run is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| irq | output | 1 | Masked status interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted/completed |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| eng_tx_load | output | 1 | One-cycle load of a transmit word into the engine |
| eng_tx_data | output | 32 | Transmit word for the engine |
| eng_word_done | input | 1 | Engine finished one 32-bit exchange |
| eng_rx_data | input | 32 | Word received by the engine, valid with `eng_word_done` |

## Verification
Runs are tried in both directions, with a count that is already aligned and with one that is not, and with an unaligned start address. These show apart the direction handling, the count truncation and the address stepping. A stopped run is set against one that runs to completion, which separates abort from done. A sub-word count tests the immediate done with no memory traffic. Processor writes to the transmit and configuration registers are made once while idle and once during a run, which shows whether the run-time ownership of the data path holds.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  localparam int DW = 32;
  localparam int RA_W = 3;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_ADDR = 3'd1;
  localparam logic [RA_W-1:0] RA_CNT  = 3'd2;
  localparam logic [RA_W-1:0] RA_DIR  = 3'd3;
  localparam logic [RA_W-1:0] RA_STS  = 3'd4;
  localparam logic [RA_W-1:0] RA_MASK = 3'd5;
  localparam logic [RA_W-1:0] RA_TX   = 3'd6;

  localparam int STS_W     = 8;
  localparam int STS_DONE  = 3;
  localparam int STS_ABORT = 4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_SHIFT = 2'd2,
    S_STORE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/spi_dma_regs.sv
module spi_dma_regs
  import spi_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RA_W-1:0]   addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic              ev_done,
  input  logic              ev_abort,
  output logic [DW-1:0]     rdata,
  output logic              start_p,
  output logic              stop_p,
  output logic              tx_wr,
  output logic [AW-1:0]     cfg_addr,
  output logic [CW-1:0]     cfg_cnt,
  output logic              cfg_dir,
  output logic [STS_W-1:0]  sts,
  output logic [STS_W-1:0]  mask,
  output logic              irq
);
  function automatic logic [AW-1:0] word_align_addr(input logic [DW-1:0] v);
    logic [AW-1:0] a;
    a = AW'(v);
    return {a[AW-1:2], 2'b00};
  endfunction

  function automatic logic [CW-1:0] word_align_cnt(input logic [DW-1:0] v);
    logic [CW-1:0] c;
    c = v[CW-1:0];
    return {c[CW-1:2], 2'b00};
  endfunction

  logic             cfg_we;
  logic [STS_W-1:0] sts_clr;
  logic [STS_W-1:0] sts_set;

  assign start_p = wr && (addr == RA_CTRL) && wdata[0];
  assign stop_p  = wr && (addr == RA_CTRL) && wdata[1];
  assign tx_wr   = wr && (addr == RA_TX);
  assign cfg_we  = wr && !busy;
  assign sts_clr = (wr && addr == RA_STS) ? wdata[STS_W-1:0] : '0;

  always_comb begin
    sts_set = '0;
    sts_set[STS_DONE]  = ev_done;
    sts_set[STS_ABORT] = ev_abort;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      cfg_cnt  <= '0;
      cfg_dir  <= 1'b0;
      sts      <= '0;
      mask     <= '0;
    end else begin
      if (cfg_we && addr == RA_ADDR) cfg_addr <= word_align_addr(wdata);
      if (cfg_we && addr == RA_CNT)  cfg_cnt  <= word_align_cnt(wdata);
      if (cfg_we && addr == RA_DIR)  cfg_dir  <= wdata[0];
      if (wr && addr == RA_MASK)     mask     <= wdata[STS_W-1:0];
      sts <= (sts & ~sts_clr) | sts_set;
    end
  end

  assign irq = |(sts & mask);

  always_comb begin
    unique case (addr)
      RA_CTRL: rdata = DW'(busy);
      RA_ADDR: rdata = DW'(cfg_addr);
      RA_CNT:  rdata = DW'(cfg_cnt);
      RA_DIR:  rdata = DW'(cfg_dir);
      RA_STS:  rdata = DW'(sts);
      RA_MASK: rdata = DW'(mask);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_dma_fsm.sv
module spi_dma_fsm
  import spi_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_p,
  input  logic           stop_p,
  input  logic           tx_wr,
  input  logic [DW-1:0]  tx_wdata,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic           cfg_dir,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           eng_word_done,
  input  logic [DW-1:0]  eng_rx_data,
  output logic           busy,
  output logic           ev_word,
  output logic           ev_done,
  output logic           ev_abort,
  output logic [AW-1:0]  cur_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  output logic           eng_tx_load,
  output logic [DW-1:0]  eng_tx_data
);
  localparam int WW = CW - 2;

  function automatic logic [WW-1:0] words_of(input logic [CW-1:0] c);
    return c[CW-1:2];
  endfunction

  dma_state_e    state;
  dma_state_e    after_word;
  logic [WW-1:0] left;
  logic          abort_pend;
  logic          last_word;
  logic          empty_start;
  logic [DW-1:0] rx_q;

  assign busy        = (state != S_IDLE);
  assign last_word   = (left == WW'(1));
  assign ev_word     = (state == S_SHIFT && eng_word_done && cfg_dir) ||
                       (state == S_STORE && mem_ack);
  assign empty_start = (state == S_IDLE) && start_p && (words_of(cfg_cnt) == '0);
  assign ev_done     = (ev_word && last_word) || empty_start;
  assign ev_abort    = ev_word && !last_word && abort_pend;
  assign after_word  = (last_word || abort_pend) ? S_IDLE :
                       (cfg_dir ? S_FETCH : S_SHIFT);

  assign mem_req   = (state == S_FETCH) || (state == S_STORE);
  assign mem_we    = (state == S_STORE);
  assign mem_wdata = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      left        <= '0;
      cur_addr    <= '0;
      abort_pend  <= 1'b0;
      rx_q        <= '0;
      eng_tx_load <= 1'b0;
      eng_tx_data <= '0;
    end else begin
      eng_tx_load <= 1'b0;
      if (stop_p && busy) abort_pend <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (start_p && !empty_start) begin
            left       <= words_of(cfg_cnt);
            cur_addr   <= cfg_addr;
            abort_pend <= 1'b0;
            if (cfg_dir) begin
              state <= S_FETCH;
            end else begin
              eng_tx_load <= 1'b1;
              eng_tx_data <= '0;
              state       <= S_SHIFT;
            end
          end else if (tx_wr) begin
            eng_tx_load <= 1'b1;
            eng_tx_data <= tx_wdata;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            eng_tx_load <= 1'b1;
            eng_tx_data <= mem_rdata;
            state       <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (eng_word_done) begin
            if (cfg_dir) begin
              state <= after_word;
            end else begin
              rx_q  <= eng_rx_data;
              state <= S_STORE;
            end
          end
        end
        S_STORE: begin
          if (mem_ack) begin
            state <= after_word;
            if (after_word == S_SHIFT) begin
              eng_tx_load <= 1'b1;
              eng_tx_data <= '0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
      if (ev_word) begin
        left     <= left - WW'(1);
        cur_addr <= cur_addr + AW'(4);
      end
    end
  end
endmodule

// File: rtl/spi_dma_seq.sv
module spi_dma_seq
  import spi_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           eng_tx_load,
  output logic [31:0]    eng_tx_data,
  input  logic           eng_word_done,
  input  logic [31:0]    eng_rx_data
);
  logic             busy;
  logic             start_p;
  logic             stop_p;
  logic             tx_wr;
  logic             ev_word;
  logic             ev_done;
  logic             ev_abort;
  logic [AW-1:0]    cfg_addr;
  logic [CW-1:0]    cfg_cnt;
  logic             cfg_dir;
  logic [AW-1:0]    cur_addr;
  logic [STS_W-1:0] sts;
  logic [STS_W-1:0] mask;

  spi_dma_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .ev_done  (ev_done),
    .ev_abort (ev_abort),
    .rdata    (reg_rdata),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .tx_wr    (tx_wr),
    .cfg_addr (cfg_addr),
    .cfg_cnt  (cfg_cnt),
    .cfg_dir  (cfg_dir),
    .sts      (sts),
    .mask     (mask),
    .irq      (irq)
  );

  spi_dma_fsm #(.AW(AW), .CW(CW)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_p       (start_p),
    .stop_p        (stop_p),
    .tx_wr         (tx_wr),
    .tx_wdata      (reg_wdata),
    .cfg_addr      (cfg_addr),
    .cfg_cnt       (cfg_cnt),
    .cfg_dir       (cfg_dir),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .eng_word_done (eng_word_done),
    .eng_rx_data   (eng_rx_data),
    .busy          (busy),
    .ev_word       (ev_word),
    .ev_done       (ev_done),
    .ev_abort      (ev_abort),
    .cur_addr      (cur_addr),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .eng_tx_load   (eng_tx_load),
    .eng_tx_data   (eng_tx_data)
  );

  assign mem_addr = cur_addr;
endmodule

// File: rtl/spi_dma_seq_chk.sv
module spi_dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          cfg_dir,
  input logic          ev_word,
  input logic          ev_done,
  input logic          ev_abort,
  input logic [7:0]    sts,
  input logic [7:0]    mask,
  input logic          irq
);
  // R9: request held with stable address and kind until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: no memory traffic while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R1: the request kind follows the direction bit
  assert_we_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_we == !cfg_dir));

  // R3: each completed word moves the address on by one word
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word |=> (mem_addr == $past(mem_addr) + AW'(4)));

  // R4: done and abort never fire together
  assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_abort}));

  // R4: a done event lands in status bit 3
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> sts[3]);

  // R8: an abort event lands in status bit 4
  assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> sts[4]);

  // R5: an enabled done event raises the interrupt
  assert_irq_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && mask[3]) |=> irq);

  // R4: only bits 3 and 4 ever carry status
  assert_sts_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & 8'hE7) == 8'h00);
endmodule

bind spi_dma_seq spi_dma_seq_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .busy     (busy),
  .cfg_dir  (cfg_dir),
  .ev_word  (ev_word),
  .ev_done  (ev_done),
  .ev_abort (ev_abort),
  .sts      (sts),
  .mask     (mask),
  .irq      (irq)
);

// File: tb/spi_dma_seq_tb.sv
module spi_dma_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        eng_tx_load;
  logic [31:0] eng_tx_data;
  logic        eng_word_done = 1'b0;
  logic [31:0] eng_rx_data = '0;

  spi_dma_seq dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  logic [31:0] m_addr, m_exp_addr;
  logic [23:0] m_cnt;
  logic        m_dir, m_active, m_abort_req;
  logic [7:0]  m_sts, m_mask;
  int          m_left;

  // responder bookkeeping
  int          loads = 0;
  int          mem_hits = 0;
  int          eng_cd = 0;
  int          rx_seq = 0;
  logic [31:0] last_rd = '0;
  logic [31:0] last_rx = '0;
  logic [31:0] cpu_exp = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {31'b0, m_active};
      3'd1: return m_addr;
      3'd2: return {8'b0, m_cnt};
      3'd3: return {31'b0, m_dir};
      3'd4: return {24'b0, m_sts};
      3'd5: return {24'b0, m_mask};
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R7 busy readback";
      3'd1: return "R3 address readback";
      3'd2: return "R2 count readback";
      3'd3: return "R1 direction readback";
      3'd4: return "R4/R6 status readback";
      3'd5: return "R5 mask readback";
      default: return "R11 empty index readback";
    endcase
  endfunction

  // reference model, advanced on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_exp_addr = '0; m_cnt = '0; m_dir = 1'b0;
      m_active = 1'b0; m_abort_req = 1'b0; m_sts = '0; m_mask = '0; m_left = 0;
    end else begin
      logic [7:0] set_bits;
      set_bits = '0;
      if (m_active && ((m_dir && eng_word_done) || (!m_dir && mem_ack))) begin
        m_left--;
        m_exp_addr += 4;
        if (m_left == 0) begin set_bits[3] = 1'b1; m_active = 1'b0; end
        else if (m_abort_req) begin set_bits[4] = 1'b1; m_active = 1'b0; end
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            if (reg_wdata[0] && !m_active) begin
              if ((m_cnt >> 2) == 0) set_bits[3] = 1'b1;
              else begin
                m_active = 1'b1; m_left = int'(m_cnt >> 2);
                m_exp_addr = m_addr; m_abort_req = 1'b0;
              end
            end else if (reg_wdata[1] && m_active) m_abort_req = 1'b1;
          end
          3'd1: if (!m_active) m_addr = reg_wdata & 32'hFFFF_FFFC;
          3'd2: if (!m_active) m_cnt = reg_wdata[23:0] & 24'hFF_FFFC;
          3'd3: if (!m_active) m_dir = reg_wdata[0];
          3'd4: m_sts = m_sts & ~reg_wdata[7:0];
          3'd5: m_mask = reg_wdata[7:0];
          default: ;
        endcase
      end
      m_sts = m_sts | set_bits;
    end
  end

  // per-clock comparison and memory/engine responders
  always @(negedge clk) begin
    if (rst_n) begin
      check(reg_rdata == exp_rd(reg_addr), rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
      check(irq == |(m_sts & m_mask), "R5 irq", {31'b0, irq}, {31'b0, |(m_sts & m_mask)});
      if (!m_active)
        check(!mem_req, "R9 idle request", {31'b0, mem_req}, 32'd0);

      if (mem_req && !mem_ack) begin
        mem_hits++;
        check(mem_addr == m_exp_addr, "R3 memory address", mem_addr, m_exp_addr);
        check(mem_we == !m_dir, "R1 access kind", {31'b0, mem_we}, {31'b0, !m_dir});
        if (mem_we) check(mem_wdata == last_rx, "R10 stored word", mem_wdata, last_rx);
        else begin
          last_rd   = mem_addr ^ 32'h5A00_00F0;
          mem_rdata = last_rd;
        end
        mem_ack = 1'b1;
      end else mem_ack = 1'b0;

      eng_word_done = 1'b0;
      if (eng_cd > 0) begin
        eng_cd--;
        if (eng_cd == 0) begin
          rx_seq++;
          last_rx = 32'hA500_0000 | rx_seq;
          eng_rx_data = last_rx;
          eng_word_done = 1'b1;
        end
      end
      if (eng_tx_load) begin
        loads++;
        if (m_active && m_dir)
          check(eng_tx_data == last_rd, "R10 fetched word loaded", eng_tx_data, last_rd);
        else if (m_active)
          check(eng_tx_data == 32'd0, "R10 zero word loaded", eng_tx_data, 32'd0);
        else
          check(eng_tx_data == cpu_exp, "R11 idle transmit write", eng_tx_data, cpu_exp);
        eng_cd = 3;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && m_active; i++) @(posedge clk);
    repeat (8) @(posedge clk);
  endtask

  task automatic look(input logic [2:0] a);
    @(posedge clk); #1; reg_addr = a;
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int l0, h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R5 reset irq", {31'b0, irq}, 32'd0);
    check(reg_rdata == 32'd0, "R4 reset status", reg_rdata, 32'd0);
    check(!mem_req, "R9 reset request", {31'b0, mem_req}, 32'd0);

    // memory-to-SPI, four words, with a dropped transmit write (R11)
    wr(3'd5, 32'h18);
    wr(3'd1, 32'h1000); wr(3'd2, 16); wr(3'd3, 1);
    l0 = loads; cpu_exp = 32'h0;
    wr(3'd0, 1);
    repeat (4) @(posedge clk);
    wr(3'd6, 32'hDEAD_BEEF);
    wait_idle();
    check(loads - l0 == 4, "R10 R11 loads per M2S run", loads - l0, 4);
    @(negedge clk);
    check(reg_rdata == 32'h8, "R4 done bit", reg_rdata, 32'h8);
    check(irq, "R5 irq on done", {31'b0, irq}, 32'd1);
    wr(3'd4, 32'h0);
    @(negedge clk);
    check(reg_rdata == 32'h8, "R6 write zero keeps", reg_rdata, 32'h8);
    wr(3'd4, 32'h8);
    @(negedge clk);
    check(reg_rdata == 32'h0 && !irq, "R6 write one clears", reg_rdata, 32'h0);

    // SPI-to-memory, unaligned address and count, config writes dropped (R12)
    wr(3'd1, 32'h2003); wr(3'd2, 14); wr(3'd3, 0);
    look(3'd1);
    check(reg_rdata == 32'h2000, "R3 aligned start", reg_rdata, 32'h2000);
    look(3'd2);
    check(reg_rdata == 32'd12, "R2 aligned count", reg_rdata, 32'd12);
    l0 = loads; h0 = mem_hits;
    wr(3'd0, 1);
    wr(3'd1, 32'h9000); wr(3'd3, 1); wr(3'd0, 1);
    wait_idle();
    check(loads - l0 == 3, "R10 loads per S2M run", loads - l0, 3);
    check(mem_hits - h0 == 3, "R1 stores per S2M run", mem_hits - h0, 3);
    look(3'd1);
    check(reg_rdata == 32'h2000, "R12 address kept", reg_rdata, 32'h2000);
    look(3'd3);
    check(reg_rdata == 32'h0, "R12 direction kept", reg_rdata, 32'h0);
    wr(3'd4, 32'hFF);

    // stopped run (R8)
    wr(3'd1, 32'h4000); wr(3'd2, 32); wr(3'd3, 1);
    h0 = mem_hits;
    wr(3'd0, 1);
    repeat (6) @(posedge clk);
    wr(3'd0, 2);
    wait_idle();
    @(negedge clk);
    check(reg_rdata == 32'h10, "R8 abort not done", reg_rdata, 32'h10);
    check(mem_hits - h0 < 8, "R8 run cut short", mem_hits - h0, 8);
    wr(3'd4, 32'h10);

    // stop while idle, sub-word start (R7)
    wr(3'd0, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reg_rdata == 32'h0, "R7 idle stop no effect", reg_rdata, 32'h0);
    wr(3'd2, 3);
    h0 = mem_hits;
    wr(3'd0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(reg_rdata == 32'h8, "R7 empty start done", reg_rdata, 32'h8);
    check(mem_hits == h0, "R7 empty start no access", mem_hits, h0);
    wr(3'd4, 32'h8);

    // largest count (R2)
    wr(3'd2, 32'hFFFF_FFFF);
    look(3'd2);
    check(reg_rdata == 32'h00FF_FFFC, "R2 largest count", reg_rdata, 32'h00FF_FFFC);

    // idle transmit write (R11)
    l0 = loads; cpu_exp = 32'h1234_5678;
    wr(3'd6, 32'h1234_5678);
    repeat (6) @(posedge clk);
    check(loads - l0 == 1, "R11 idle write loads", loads - l0, 1);

    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule